// File: doc/BRIEF.md
# Supervisory Reset Sequencer with Filtered Manual Request

This block drives the reset line of a processor from two causes: a supply-undervoltage flag that has already been digitized and synchronized to the block clock, and a raw, active-low manual request line that may come from a bouncing switch or a long cable. While either cause is present the reset stays asserted. Once the last cause has gone away, a hold-off counter keeps the reset asserted for a fixed number of clock cycles so that the supply and the processor can settle. Any new cause during that window reloads the counter, so the full window always runs from the last cause.

The manual line is brought into the clock domain by a two-flop synchronizer and then passes through a glitch filter. The filter moves its output only after the synchronized line has held a new level for `FILTER_CYCLES` consecutive clock edges. That rejects short spikes and accepts any deliberate press. A parameter picks active-low or active-high polarity for the reset pin. A second output always reports the asserted state as a high level, whatever the pin polarity. An asynchronous power-on reset puts the block in the asserted state, and the manual path comes out of it reading the line as released.

Top module: `supv_reset_seq`

## Requirements
- R1: While `por_i` is high, `reset_active_o` is 1. With no cause present afterwards, it falls at the (HOLD_CYCLES+1)-th rising edge after `por_i` is removed.
- R2: After any rising edge that samples `uv_i` = 1, `reset_active_o` is 1.
- R3: `reset_active_o` falls exactly at edge L+HOLD_CYCLES+1, where L is the last rising edge that sampled a reset cause (undervoltage high or filtered manual request active). It does not fall earlier or later.
- R4: A cause that appears while the hold-off is running restarts the full HOLD_CYCLES window from the new cause.
- R5: A manual low pulse that covers fewer than FILTER_CYCLES consecutive sampling edges has no effect on `reset_active_o` or `rst_o`.
- R6: The filtered manual request follows the line with a two-edge synchronizer delay. It changes level only after FILTER_CYCLES consecutive equal samples. For a low pulse of at least FILTER_CYCLES sampled edges, counting the first edge that samples it low as edge 1, `reset_active_o` rises at edge FILTER_CYCLES+3.
- R7: While a manual request is held, high blips on the line that cover fewer than FILTER_CYCLES sampled edges do not end the request.
- R8: With ACTIVE_LOW = 1, `rst_o` is the inverse of `reset_active_o`. With ACTIVE_LOW = 0, `rst_o` equals `reset_active_o`. Timing is the same for both.
- R9: The synchronizer and the filter leave power-on reset holding the released (high) level. A manual line held high therefore never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Asynchronous power-on reset, active high |
| uv_i | input | 1 | Synchronous supply-undervoltage flag, high = supply low |
| mr_n_i | input | 1 | Raw manual reset request, active low, high when idle |
| rst_o | output | 1 | Reset to the processor, polarity set by ACTIVE_LOW |
| reset_active_o | output | 1 | Asserted state, always active high |

## Verification
The bench targets the exact release edge after power-on, after a one-cycle undervoltage pulse, and after a second cause lands in the middle of a hold-off. A counter that is off by one, or one that continues instead of reloading, moves the release edge and is reported. Manual pulses of exactly FILTER_CYCLES-1 and FILTER_CYCLES sampled edges bracket the filter threshold. A filter that counts one short would let the first pulse through, and a filter that loses its count would reset the processor on noise. Bounce blips inside a held request check that the filter does not release early. Random mixes of both causes, including overlapping ones, are compared every cycle against a reference built from the timing rules, with both output polarities instantiated side by side.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // Hold-off sequencer state
    typedef enum logic [1:0] {
        HS_CAUSE = 2'd0,   // a cause is present, counter parked at reload
        HS_COUNT = 2'd1,   // causes gone, counting down
        HS_IDLE  = 2'd2    // released
    } hold_state_e;

    // The two reset sources after conditioning
    typedef struct packed {
        logic undervolt;
        logic manual;
    } reset_cause_t;

    function automatic logic cause_present(input reset_cause_t c);
        return c.undervolt | c.manual;
    endfunction

    // Bits needed to hold values 0..max_val
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i) chain[i] <= RESET_VAL;
                else       chain[i] <= d_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i) chain[i] <= RESET_VAL;
                else       chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/supv_glitch_filter.sv
module supv_glitch_filter #(
    parameter int   FILTER_CYCLES = 100,
    parameter logic RESET_VAL     = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = supv_reset_pkg::cnt_width(FILTER_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(FILTER_CYCLES - 1);

    logic          level_q;
    logic [CW-1:0] run_q;

    // Counts consecutive samples that disagree with the held level
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            level_q <= RESET_VAL;
            run_q   <= '0;
        end else if (d_i == level_q) begin
            run_q   <= '0;
        end else if (run_q == LAST) begin
            level_q <= d_i;
            run_q   <= '0;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    assign q_o = level_q;
endmodule

// File: rtl/supv_holdoff.sv
module supv_holdoff #(
    parameter int HOLD_CYCLES = 12_000_000
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  supv_reset_pkg::reset_cause_t cause_i,
    output logic                         active_o
);
    timeunit 1ns;
    timeprecision 100ps;
    import supv_reset_pkg::*;

    localparam int CW = cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES);

    hold_state_e   state_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= HS_CAUSE;
            left_q  <= RELOAD;
        end else if (cause_present(cause_i)) begin
            state_q <= HS_CAUSE;
            left_q  <= RELOAD;
        end else if (left_q != '0) begin
            state_q <= HS_COUNT;
            left_q  <= left_q - 1'b1;
        end else begin
            state_q <= HS_IDLE;
        end
    end

    assign active_o = (state_q != HS_IDLE);
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
    parameter int HOLD_CYCLES   = 12_000_000,
    parameter int FILTER_CYCLES = 100,
    parameter int SYNC_STAGES   = 2,
    parameter bit ACTIVE_LOW    = 1'b1
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic uv_i,
    input  logic mr_n_i,
    output logic rst_o,
    output logic reset_active_o
);
    timeunit 1ns;
    timeprecision 100ps;
    import supv_reset_pkg::*;

    logic         mr_sync;
    logic         mr_filt_n;
    reset_cause_t cause;
    logic         active;

    supv_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk_i(clk_i),
        .rst_i(por_i),
        .d_i  (mr_n_i),
        .q_o  (mr_sync)
    );

    supv_glitch_filter #(
        .FILTER_CYCLES(FILTER_CYCLES),
        .RESET_VAL    (1'b1)
    ) u_filter (
        .clk_i(clk_i),
        .rst_i(por_i),
        .d_i  (mr_sync),
        .q_o  (mr_filt_n)
    );

    assign cause.undervolt = uv_i;
    assign cause.manual    = ~mr_filt_n;

    supv_holdoff #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_holdoff (
        .clk_i   (clk_i),
        .rst_i   (por_i),
        .cause_i (cause),
        .active_o(active)
    );

    assign reset_active_o = active;

    if (ACTIVE_LOW) begin : g_low
        assign rst_o = ~active;
    end else begin : g_high
        assign rst_o = active;
    end
endmodule

// File: rtl/supv_reset_seq_checker.sv
module supv_reset_seq_checker #(
    parameter int HOLD_CYCLES   = 12_000_000,
    parameter int FILTER_CYCLES = 100
) (
    input logic clk_i,
    input logic por_i,
    input logic uv_i,
    input logic mr_sync_i,
    input logic mr_req_n_i,
    input logic reset_active_i
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int QW = supv_reset_pkg::cnt_width(HOLD_CYCLES + 2);
    localparam int RW = supv_reset_pkg::cnt_width(FILTER_CYCLES);
    localparam logic [QW-1:0] QMAX = QW'(HOLD_CYCLES + 2);
    localparam logic [RW-1:0] RMAX = RW'(FILTER_CYCLES);

    logic [QW-1:0] quiet_q;
    logic [RW-1:0] same_q;
    logic          prev_q;

    // Edges since the last edge that sampled a cause
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)                         quiet_q <= '0;
        else if (uv_i || !mr_req_n_i)      quiet_q <= '0;
        else if (quiet_q != QMAX)          quiet_q <= quiet_q + 1'b1;
    end

    // Length of the current run of equal synchronized samples
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            prev_q <= 1'b1;
            same_q <= '0;
        end else begin
            prev_q <= mr_sync_i;
            if (mr_sync_i != prev_q) same_q <= RW'(1);
            else if (same_q != RMAX) same_q <= same_q + 1'b1;
        end
    end

    assert_por_hold_R1: assert property (@(posedge clk_i)
        por_i |-> reset_active_i);

    assert_uv_forces_R2: assert property (@(posedge clk_i) disable iff (por_i)
        uv_i |=> reset_active_i);

    assert_release_timing_R3: assert property (@(posedge clk_i) disable iff (por_i)
        (quiet_q > QW'(HOLD_CYCLES)) |-> !reset_active_i);

    assert_hold_window_R4: assert property (@(posedge clk_i) disable iff (por_i)
        (quiet_q <= QW'(HOLD_CYCLES)) |-> reset_active_i);

    assert_filter_stable_R6: assert property (@(posedge clk_i) disable iff (por_i)
        !$stable(mr_req_n_i) |-> (same_q >= RMAX));
endmodule

bind supv_reset_seq supv_reset_seq_checker #(
    .HOLD_CYCLES  (HOLD_CYCLES),
    .FILTER_CYCLES(FILTER_CYCLES)
) u_chk (
    .clk_i         (clk_i),
    .por_i         (por_i),
    .uv_i          (uv_i),
    .mr_sync_i     (mr_sync),
    .mr_req_n_i    (mr_filt_n),
    .reset_active_i(reset_active_o)
);

// File: tb/supv_reset_seq_bench.sv
module supv_reset_seq_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int H = 40;
    localparam int F = 5;

    logic clk = 1'b0;
    logic por;
    logic uv = 1'b0;
    logic mr_n = 1'b1;
    logic rst_lo, act_lo, rst_hi, act_hi;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    supv_reset_seq #(.HOLD_CYCLES(H), .FILTER_CYCLES(F), .ACTIVE_LOW(1'b1)) u_supv_reset_seq (
        .clk_i(clk), .por_i(por), .uv_i(uv), .mr_n_i(mr_n),
        .rst_o(rst_lo), .reset_active_o(act_lo));

    supv_reset_seq #(.HOLD_CYCLES(H), .FILTER_CYCLES(F), .ACTIVE_LOW(1'b0)) u_supv_reset_seq_hi (
        .clk_i(clk), .por_i(por), .uv_i(uv), .mr_n_i(mr_n),
        .rst_o(rst_hi), .reset_active_o(act_hi));

    // Reference state built from the timing rules
    int   m_since;          // edges since last cause edge
    logic m_s1, m_s2;       // two-edge synchronizer delay of the line
    logic m_lvl;            // filtered line level
    logic m_hist [F];       // last F synchronized samples
    logic m_uv_last;

    function automatic logic exp_active();
        return m_since <= H;
    endfunction

    task automatic model_reset();
        m_since = 0; m_s1 = 1'b1; m_s2 = 1'b1; m_lvl = 1'b1; m_uv_last = 1'b0;
        for (int i = 0; i < F; i++) m_hist[i] = 1'b1;
    endtask

    task automatic model_edge(input logic u, input logic m);
        logic all_same;
        if (u || !m_lvl) begin
            m_since = 0;
            m_uv_last = u;
        end else if (m_since <= H) begin
            m_since++;
        end
        for (int i = F - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = m_s2;
        all_same = 1'b1;
        for (int i = 1; i < F; i++) if (m_hist[i] != m_hist[0]) all_same = 1'b0;
        if (all_same && m_hist[0] != m_lvl) m_lvl = m_hist[0];
        m_s2 = m_s1;
        m_s1 = m;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, let the edge happen, compare at the next negedge
    task automatic step(input logic u, input logic m);
        string tag;
        uv = u; mr_n = m;
        @(posedge clk);
        model_edge(u, m);
        @(negedge clk);
        if (m_since == 0)      tag = m_uv_last ? "R2" : "R6";
        else if (m_since <= H) tag = "R3";
        else                   tag = "R5";
        chk(act_lo, exp_active(), tag);
        chk(rst_lo, ~exp_active(), "R8 low polarity");
        chk(rst_hi, exp_active(), "R8 high polarity");
        chk(act_hi, exp_active(), "R8 status fixed");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seg;
        int len;
        void'($urandom(32'd20240611));
        por = 1'b1;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(act_lo, 1'b1, "R1 active in power-on reset");
        chk(rst_lo, 1'b0, "R1 low pin in power-on reset");
        chk(rst_hi, 1'b1, "R1 high pin in power-on reset");
        por = 1'b0;

        // R1: release after exactly H+1 edges
        idle(H);
        chk(act_lo, 1'b1, "R1 still held at edge H");
        idle(1);
        chk(act_lo, 1'b0, "R1 released at edge H+1");
        idle(50);
        chk(act_lo, 1'b0, "R9 idle line never requests");

        // R2/R3: one-cycle undervoltage pulse
        step(1'b1, 1'b1);
        chk(act_lo, 1'b1, "R2 undervoltage asserts");
        idle(H);
        chk(act_lo, 1'b1, "R3 held through window");
        idle(1);
        chk(act_lo, 1'b0, "R3 released after window");
        idle(5);

        // R4: retrigger inside the window
        step(1'b1, 1'b1);
        idle(20);
        step(1'b1, 1'b1);
        idle(H);
        chk(act_lo, 1'b1, "R4 window restarted");
        idle(1);
        chk(act_lo, 1'b0, "R4 release from second cause");
        idle(5);

        // R5: pulse one sample short of the filter length
        for (int i = 0; i < F - 1; i++) step(1'b0, 1'b0);
        idle(F + 6);
        chk(act_lo, 1'b0, "R5 short manual pulse rejected");
        chk(rst_lo, 1'b1, "R5 pin untouched by short pulse");

        // R6: pulse of exactly the filter length
        for (int i = 0; i < F; i++) step(1'b0, 1'b0);
        idle(1);
        chk(act_lo, 1'b0, "R6 not yet asserted at edge F+1");
        idle(1);
        chk(act_lo, 1'b0, "R6 not yet asserted at edge F+2");
        idle(1);
        chk(act_lo, 1'b1, "R6 asserted at edge F+3");
        idle(H + F + 10);
        chk(act_lo, 1'b0, "R6 released after manual request");

        // R7: held request with bounce blips
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
        for (int b = 1; b < F; b++) begin
            for (int i = 0; i < b; i++) step(1'b0, 1'b1);
            for (int i = 0; i < F + 2; i++) step(1'b0, 1'b0);
            chk(act_lo, 1'b1, "R7 bounce does not release");
        end
        idle(H + F + 10);

        // R4: overlapping causes, release follows the later one
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
        idle(H + 5);
        chk(act_lo, 1'b0, "R4 overlap released");

        // Random mix
        for (int n = 0; n < 700; n++) begin
            seg = $urandom_range(0, 4);
            case (seg)
                0: idle($urandom_range(1, H + 15));
                1: begin
                    len = $urandom_range(1, 6);
                    for (int i = 0; i < len; i++) step(1'b1, 1'b1);
                end
                2: begin
                    len = $urandom_range(1, 2 * F + 1);
                    for (int i = 0; i < len; i++) step(1'b0, 1'b0);
                end
                3: begin
                    len = $urandom_range(F, 3 * F);
                    for (int i = 0; i < len; i++)
                        step(1'b0, ($urandom_range(0, 5) == 0) ? 1'b1 : 1'b0);
                end
                default: begin
                    len = $urandom_range(1, 2 * F);
                    for (int i = 0; i < len; i++)
                        step($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0);
                end
            endcase
        end
        idle(H + F + 10);
        chk(act_lo, 1'b0, "R3 final release");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule